// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a synchronous four-beat burst memory access. When an access starts, it captures an external address in a register. An access starts through one of two active-low strobes: one driven by the processor, one driven by a cache controller. On every later clock where the active-low advance input is low, an internal two-bit beat counter steps. Only the two low address bits follow that counter. The upper bits keep the captured value for the whole burst.

The beat order is taken from a mode input at the moment the burst starts.
- **Linear:** the low bits count up modulo four from the starting value.
- **Interleaved:** the low bits equal the starting value XOR the number of beats taken.

Three chip selects qualify the strobes:
- a primary select, active low;
- a second select, active high;
- a third select, active low.

The processor strobe is blocked entirely while the primary select is high. When the primary select is low but one of the other two selects is inactive, the processor strobe ends the current burst. The controller strobe starts a burst only when all three selects are active. Otherwise it has no effect.

The memory array, data path and output drivers sit outside this block. The block hands them `addr_out` and `burst_active`. Both change only on the rising clock edge.

Top module: `burst_addr_seq`

## Requirements
- R1: A low `ctl_stb_n` while `cs_main_n`=0, `cs_hi`=1 and `cs_lo_n`=0 (with no valid processor strobe) captures `addr_in`. After that edge, `addr_out` equals the captured address and `burst_active`=1.
- R2: A low `cpu_stb_n` while `cs_main_n`=0, `cs_hi`=1 and `cs_lo_n`=0 captures `addr_in` in the same way, and the beat count restarts at zero.
- R3: While `cs_main_n`=1, a low `cpu_stb_n` changes neither `addr_out` nor `burst_active`.
- R4: When both strobes are low in one cycle, the processor strobe decides the outcome. A low `ctl_stb_n` alone with the secondary selects inactive has no effect.
- R5: With `interleave`=0 at burst start, after n advances `addr_out[1:0]` = (start + n) mod 4.
- R6: With `interleave`=1 at burst start, after n advances `addr_out[1:0]` = start XOR (n mod 4).
- R7: The order is sampled only when a burst starts. Changing `interleave` during a burst does not alter the sequence.
- R8: On a clock where `adv_n`=1, or while no burst is active, the address holds.
- R9: After four advances the low bits return to their starting value, with no carry into `addr_out[ADDR_W-1:2]`. The upper bits stay fixed throughout the burst.
- R10: A qualifying strobe in the middle of a burst reloads the address and restarts the count, even when `adv_n`=0 in that cycle.
- R11: A low `cpu_stb_n` with `cs_main_n`=0 but `cs_hi`=0 or `cs_lo_n`=1 ends the burst: `burst_active`=0 and `addr_out` holds.
- R12: After reset, `addr_out`=0 and `burst_active`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_in | input | ADDR_W | External address captured when a burst starts |
| cs_main_n | input | 1 | Primary chip select, active low; also gates the processor strobe |
| cs_hi | input | 1 | Secondary chip select, active high |
| cs_lo_n | input | 1 | Third chip select, active low |
| cpu_stb_n | input | 1 | Processor address strobe, active low |
| ctl_stb_n | input | 1 | Cache-controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| interleave | input | 1 | Beat order at burst start: 1 interleaved, 0 linear |
| addr_out | output | ADDR_W | Current burst word address |
| burst_active | output | 1 | High while a burst is in progress |

## Verification
The bench covers every starting low value in both orders, under several upper-address patterns and an uneven advance pattern.

| Corner case | What a faulty design would do |
|---|---|
| Counter wrap after the fourth beat | Carry into bit 2, or fail to come back to the starting value |
| Order switched during a burst | Follow the live `interleave` input and jump to the other order partway through |
| Strobes colliding in one cycle | Let the controller strobe win and keep the burst alive when it should end |
| Processor strobe with the primary select high | Reload or kill the burst when it should be blocked |
| Strobe mid-burst with `adv_n` low | Keep counting instead of restarting at the new address |

// File: rtl/bas_pkg.sv
package bas_pkg;
  // Two low address bits follow the burst beat counter (four beats).
  localparam int BEAT_W = 2;

  // Low address bits for a given start value, beats taken, and order.
  function automatic logic [BEAT_W-1:0] beat_lo(
    input logic [BEAT_W-1:0] start,
    input logic [BEAT_W-1:0] cnt,
    input logic              ilv
  );
    logic [BEAT_W-1:0] res;
    if (ilv) res = start ^ cnt;
    else     res = start + cnt;
    return res;
  endfunction
endpackage

// File: rtl/bas_strobe_qual.sv
module bas_strobe_qual (
  input  logic cpu_stb_n,
  input  logic ctl_stb_n,
  input  logic cs_main_n,
  input  logic cs_hi,
  input  logic cs_lo_n,
  output logic load,
  output logic drop
);
  logic cpu_ok;
  logic chip_sel;

  assign cpu_ok   = !cpu_stb_n && !cs_main_n;
  assign chip_sel = !cs_main_n && cs_hi && !cs_lo_n;

  always_comb begin
    load = 1'b0;
    drop = 1'b0;
    if (cpu_ok) begin
      // Processor strobe wins; a partial select ends the burst.
      if (chip_sel) load = 1'b1;
      else          drop = 1'b1;
    end else if (!ctl_stb_n && chip_sel) begin
      load = 1'b1;
    end
  end
endmodule

// File: rtl/bas_beat_ctr.sv
module bas_beat_ctr #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (step)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/bas_addr_hold.sv
module bas_addr_hold #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              drop,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              mode_in,
  output logic [ADDR_W-1:0] base_q,
  output logic              mode_q,
  output logic              active_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      mode_q   <= 1'b0;
      active_q <= 1'b0;
    end else if (load) begin
      base_q   <= addr_in;
      mode_q   <= mode_in;
      active_q <= 1'b1;
    end else if (drop) begin
      active_q <= 1'b0;
    end
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              cs_main_n,
  input  logic              cs_hi,
  input  logic              cs_lo_n,
  input  logic              cpu_stb_n,
  input  logic              ctl_stb_n,
  input  logic              adv_n,
  input  logic              interleave,
  output logic [ADDR_W-1:0] addr_out,
  output logic              burst_active
);
  import bas_pkg::*;

  localparam int LO_W = BEAT_W;
  localparam int HI_W = ADDR_W - LO_W;

  // Named internal events, visible to the bound checker.
  logic              load_evt;
  logic              drop_evt;
  logic              adv_evt;
  logic [ADDR_W-1:0] base_q;
  logic              mode_q;
  logic              active_q;
  logic [LO_W-1:0]   beat_q;
  logic [LO_W-1:0]   lo_now;

  bas_strobe_qual u_qual (
    .cpu_stb_n (cpu_stb_n),
    .ctl_stb_n (ctl_stb_n),
    .cs_main_n (cs_main_n),
    .cs_hi     (cs_hi),
    .cs_lo_n   (cs_lo_n),
    .load      (load_evt),
    .drop      (drop_evt)
  );

  // Advance only inside a burst, and never on a strobe cycle.
  assign adv_evt = active_q && !adv_n && !load_evt && !drop_evt;

  bas_beat_ctr #(.W(LO_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (load_evt),
    .step  (adv_evt),
    .cnt   (beat_q)
  );

  bas_addr_hold #(.ADDR_W(ADDR_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_evt),
    .drop     (drop_evt),
    .addr_in  (addr_in),
    .mode_in  (interleave),
    .base_q   (base_q),
    .mode_q   (mode_q),
    .active_q (active_q)
  );

  assign lo_now = beat_lo(base_q[LO_W-1:0], beat_q, mode_q);

  generate
    if (HI_W > 0) begin : g_with_hi
      assign addr_out = {base_q[ADDR_W-1:LO_W], lo_now};
    end else begin : g_lo_only
      assign addr_out = lo_now;
    end
  endgenerate

  assign burst_active = active_q;
endmodule

// File: rtl/bas_seq_checker.sv
module bas_seq_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_in,
  input logic              cs_main_n,
  input logic              cpu_stb_n,
  input logic              ctl_stb_n,
  input logic              adv_n,
  input logic              interleave,
  input logic [ADDR_W-1:0] addr_out,
  input logic              burst_active,
  input logic              load_evt,
  input logic              drop_evt,
  input logic              adv_evt
);
  // Independent shadow of the burst: start bits, order, and beat count.
  logic [1:0] chk_start;
  logic [1:0] chk_cnt;
  logic       chk_ilv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_start <= '0;
      chk_cnt   <= '0;
      chk_ilv   <= 1'b0;
    end else if (load_evt) begin
      chk_start <= addr_in[1:0];
      chk_cnt   <= '0;
      chk_ilv   <= interleave;
    end else if (adv_evt) begin
      chk_cnt   <= chk_cnt + 2'd1;
    end
  end

  p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (burst_active && addr_out == $past(addr_in)));

  p_cpu_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_stb_n && cs_main_n && ctl_stb_n && adv_n)
      |=> ($stable(addr_out) && $stable(burst_active)));

  p_linear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_active && !chk_ilv) |-> (addr_out[1:0] == 2'(chk_start + chk_cnt)));

  p_interleave_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_active && chk_ilv) |-> (addr_out[1:0] == (chk_start ^ chk_cnt)));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && !drop_evt && adv_n) |=> $stable(addr_out));

  p_upper_fixed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_active && !load_evt) |=> $stable(addr_out[ADDR_W-1:2]));

  p_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> (!burst_active && $stable(addr_out)));
endmodule

bind burst_addr_seq bas_seq_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .addr_in      (addr_in),
  .cs_main_n    (cs_main_n),
  .cpu_stb_n    (cpu_stb_n),
  .ctl_stb_n    (ctl_stb_n),
  .adv_n        (adv_n),
  .interleave   (interleave),
  .addr_out     (addr_out),
  .burst_active (burst_active),
  .load_evt     (load_evt),
  .drop_evt     (drop_evt),
  .adv_evt      (adv_evt)
);

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] addr_in;
  logic        cs_main_n, cs_hi, cs_lo_n;
  logic        cpu_stb_n, ctl_stb_n, adv_n, interleave;
  logic [15:0] addr_out;
  logic        burst_active;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Bench model of the burst in progress.
  logic [15:0] m_base;
  int          m_start;
  int          m_n;
  bit          m_ilv;

  always #4 clk = ~clk;

  burst_addr_seq #(.ADDR_W(16)) i_burst_addr_seq (
    .clk, .rst_n, .addr_in, .cs_main_n, .cs_hi, .cs_lo_n,
    .cpu_stb_n, .ctl_stb_n, .adv_n, .interleave,
    .addr_out, .burst_active
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Settle on the next rising edge; inputs change 1 ns after it.
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    cs_main_n = 1'b0; cs_hi = 1'b1; cs_lo_n = 1'b0;
    cpu_stb_n = 1'b1; ctl_stb_n = 1'b1; adv_n = 1'b1;
  endtask

  function automatic logic [15:0] model_addr();
    int lo;
    if (m_ilv) lo = m_start ^ (m_n % 4);
    else       lo = (m_start + m_n) % 4;
    return {m_base[15:2], 2'(lo)};
  endfunction

  task automatic start_burst(input bit use_cpu, input logic [15:0] a, input bit ilv);
    idle();
    addr_in = a; interleave = ilv;
    if (use_cpu) cpu_stb_n = 1'b0; else ctl_stb_n = 1'b0;
    step();
    idle();
    m_base = a; m_start = int'(a[1:0]); m_n = 0; m_ilv = ilv;
    chk(use_cpu ? "R2 load" : "R1 load", addr_out, a);
    chk(use_cpu ? "R2 active" : "R1 active", {15'd0, burst_active}, 16'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] uppers [3];
    logic [15:0] held;
    uppers[0] = 16'h0000; uppers[1] = 16'hABC8; uppers[2] = 16'hFFFC;
    idle();
    addr_in = 16'h0; interleave = 1'b0;
    rst_n = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    // R12: reset state.
    chk("R12 addr", addr_out, 16'h0);
    chk("R12 active", {15'd0, burst_active}, 16'd0);

    // R8: advance while idle has no effect.
    adv_n = 1'b0; step(); idle();
    chk("R8 idle adv", addr_out, 16'h0);

    // Sweep: order x start bits x upper pattern, uneven advance pattern.
    for (int md = 0; md < 2; md++) begin
      for (int s = 0; s < 4; s++) begin
        for (int u = 0; u < 3; u++) begin
          start_burst(((s + u) % 2) == 1, uppers[u] | 16'(s), md[0]);
          for (int k = 0; k < 10; k++) begin
            bit adv;
            adv = (k % 3) != 2;
            adv_n = !adv;
            interleave = !md[0]; // R7: changing the order mid-burst is ignored
            step();
            if (adv) m_n++;
            if (!adv)              chk("R8 hold", addr_out, model_addr());
            else if (m_n % 4 == 0) chk("R9 wrap", addr_out, model_addr());
            else if (md == 0)      chk("R5 linear R7", addr_out, model_addr());
            else                   chk("R6 interleave R7", addr_out, model_addr());
          end
          idle();
        end
      end
    end

    // R3: processor strobe blocked while the primary select is high.
    start_burst(1'b0, 16'h5A5D, 1'b0);
    adv_n = 1'b0; step(); m_n++; idle();
    held = model_addr();
    cs_main_n = 1'b1; cpu_stb_n = 1'b0; addr_in = 16'h1111;
    step(); idle();
    chk("R3 addr", addr_out, held);
    chk("R3 active", {15'd0, burst_active}, 16'd1);

    // R10: mid-burst reload with advance asserted restarts the count.
    ctl_stb_n = 1'b0; adv_n = 1'b0; addr_in = 16'h2222; interleave = 1'b1;
    step(); idle();
    m_base = 16'h2222; m_start = 2; m_n = 0; m_ilv = 1'b1;
    chk("R10 reload", addr_out, 16'h2222);
    adv_n = 1'b0; step(); idle(); m_n++;
    chk("R10 restart", addr_out, model_addr());

    // R4: controller strobe alone with a secondary select inactive is ignored.
    held = addr_out;
    cs_hi = 1'b0; ctl_stb_n = 1'b0; addr_in = 16'h3333;
    step(); idle();
    chk("R4 ctl ignored addr", addr_out, held);
    chk("R4 ctl ignored active", {15'd0, burst_active}, 16'd1);

    // R4: both strobes, partial select: processor decides, so the burst ends.
    cs_hi = 1'b0; ctl_stb_n = 1'b0; cpu_stb_n = 1'b0; addr_in = 16'h4444;
    step(); idle();
    chk("R4 both drop active", {15'd0, burst_active}, 16'd0);
    chk("R4 both drop addr", addr_out, held);

    // R4: both strobes, full select: load.
    ctl_stb_n = 1'b0; cpu_stb_n = 1'b0; addr_in = 16'h6667; interleave = 1'b0;
    step(); idle();
    chk("R4 both load", addr_out, 16'h6667);
    chk("R4 both active", {15'd0, burst_active}, 16'd1);

    // R11: processor strobe with the third select inactive ends the burst.
    cs_lo_n = 1'b1; cpu_stb_n = 1'b0; adv_n = 1'b0; addr_in = 16'h7777;
    step(); idle();
    chk("R11 active", {15'd0, burst_active}, 16'd0);
    chk("R11 addr", addr_out, 16'h6667);
    adv_n = 1'b0; step(); idle();
    chk("R8 adv after end", addr_out, 16'h6667);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule